// File: doc/BRIEF.md
# Edge-Pattern Digital Trigger Qualifier

This block watches a bus of sampled digital trigger lines and produces a one-cycle trigger pulse when a selected line makes a chosen transition while the other lines satisfy a programmed qualifier. Each of the other lines can be required low, required high, or left out of the test. The checked lines can be combined in two ways. In the all-of mode every one of them must match. In the any-of mode one matching line is enough.

Samples arrive as a stream beat: `samp_valid` marks a cycle whose `samp_data` is a new sample. There is no `ready`, so the block never applies back-pressure. Every beat is accepted on the clock edge where `samp_valid` is high. A cycle with `samp_valid` low carries nothing and leaves all history untouched. A second output, `qual_out`, carries the qualifier result for the last accepted sample. An analog trigger source elsewhere can use it as a digital gate.

Configuration is loaded through a small write-only register port.

Top module: `trig_edge_qualifier`

## Requirements
- R1: After reset `trig_out` and `qual_out` are 0. The configuration resets to check mask 0x00, value 0x00, source line 0, rising edge and all-of mode.
- R2: A write with `cfg_we` high loads a register from `cfg_wdata`, and the new value applies to beats accepted from the next clock edge on.
  - Address 0 is the check mask: a 1 means the line is tested.
  - Address 1 is the required level of each line.
  - Address 2 is control: bits [2:0] give the source line, bit 3 gives the edge (0 rising, 1 falling), and bit 4 gives the mode (0 all-of, 1 any-of).
  - A write to address 3 changes nothing.
- R3: With bit 3 of control at 0, an edge is seen when the source line was 0 in the previous accepted sample and is 1 in the current one.
- R4: With bit 3 of control at 1, an edge is seen when the source line was 1 in the previous accepted sample and is 0 in the current one.
- R5: The first beat accepted after reset never produces a trigger.
- R6: In all-of mode the qualifier is true when every checked line equals its required level. It is also true when no line is checked.
- R7: In any-of mode the qualifier is true when at least one checked line equals its required level. It is also true when no line is checked.
- R8: The source line is never part of the qualifier, whatever its mask bit says.
- R9: `trig_out` is high for exactly the one cycle after the edge that accepted a beat with both an edge and a true qualifier. `qual_out` is updated on every accepted beat and holds its value between beats.
- R10: Cycles with `samp_valid` low do not update the previous sample, do not trigger, and leave `qual_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| samp_valid | input | 1 | Sample beat valid |
| samp_data | input | 8 | Sampled trigger lines |
| trig_out | output | 1 | One-cycle trigger pulse |
| qual_out | output | 1 | Qualifier result of last accepted sample |

## Verification
Both outputs are registered once. The trigger and qualifier results for a beat accepted at one clock edge are therefore visible just after that edge, and the bench samples them 1 ns later. A configuration write captured at one edge governs the beat accepted at the following edge. The bench therefore never issues a write and a beat in the same cycle. It keeps its own model of the previous accepted sample, so idle cycles placed inside the sweeps show that history and `qual_out` stay put.

// File: rtl/trig_qual_pkg.sv
package trig_qual_pkg;
  typedef enum logic { EDGE_RISE = 1'b0, EDGE_FALL = 1'b1 } edge_pol_e;
  typedef enum logic { COMB_ALL  = 1'b0, COMB_ANY  = 1'b1 } combine_e;

  localparam int unsigned ADDR_W    = 2;
  localparam logic [1:0]  ADDR_MASK = 2'd0;
  localparam logic [1:0]  ADDR_VAL  = 2'd1;
  localparam logic [1:0]  ADDR_CTRL = 2'd2;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_qual_pkg::*;
#(
  parameter int unsigned NUM_IN = 8,
  parameter int unsigned SRC_W  = $clog2(NUM_IN),
  parameter int unsigned CFG_W  = NUM_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [NUM_IN-1:0] chk_mask,
  output logic [NUM_IN-1:0] chk_val,
  output logic [SRC_W-1:0]  src_idx,
  output edge_pol_e         edge_pol,
  output combine_e          comb_mode
);
  localparam int unsigned POL_BIT  = SRC_W;
  localparam int unsigned MODE_BIT = SRC_W + 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_mask  <= '0;
      chk_val   <= '0;
      src_idx   <= '0;
      edge_pol  <= EDGE_RISE;
      comb_mode <= COMB_ALL;
    end else if (cfg_we) begin
      case (cfg_addr)
        ADDR_MASK: chk_mask <= cfg_wdata[NUM_IN-1:0];
        ADDR_VAL:  chk_val  <= cfg_wdata[NUM_IN-1:0];
        ADDR_CTRL: begin
          src_idx   <= cfg_wdata[SRC_W-1:0];
          edge_pol  <= edge_pol_e'(cfg_wdata[POL_BIT]);
          comb_mode <= combine_e'(cfg_wdata[MODE_BIT]);
        end
        default: ;
      endcase
    end
  end

  // R2: a mask write lands in the mask register
  assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_MASK) |=> (chk_mask == $past(cfg_wdata[NUM_IN-1:0])));

  // R2: the unused address leaves every register alone
  assert_spare_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd3) |=> ($stable(chk_mask) && $stable(chk_val) && $stable(src_idx)));
endmodule

// File: rtl/trig_edge_detect.sv
module trig_edge_detect
  import trig_qual_pkg::*;
#(
  parameter int unsigned NUM_IN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [NUM_IN-1:0] samp_data,
  input  logic [NUM_IN-1:0] src_oh,
  input  edge_pol_e         edge_pol,
  output logic              edge_hit
);
  logic [NUM_IN-1:0] prev_q;
  logic              have_prev_q;
  logic              cur_bit, prv_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (samp_valid) begin
      prev_q      <= samp_data;
      have_prev_q <= 1'b1;
    end
  end

  assign cur_bit = |(samp_data & src_oh);
  assign prv_bit = |(prev_q & src_oh);

  always_comb begin
    if (!have_prev_q)              edge_hit = 1'b0;
    else if (edge_pol == EDGE_RISE) edge_hit = cur_bit & ~prv_bit;
    else                            edge_hit = ~cur_bit & prv_bit;
  end

  // R10: idle cycles keep the history
  assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_valid |=> ($stable(prev_q) && $stable(have_prev_q)));

  // R5: history becomes available once a beat is accepted
  assert_hist_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid |=> have_prev_q);
endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier
  import trig_qual_pkg::*;
#(
  parameter int unsigned NUM_IN = 8
) (
  input  logic [NUM_IN-1:0] samp_data,
  input  logic [NUM_IN-1:0] chk_mask,
  input  logic [NUM_IN-1:0] chk_val,
  input  logic [NUM_IN-1:0] src_oh,
  input  combine_e          comb_mode,
  output logic              match
);
  logic [NUM_IN-1:0] chk_bits;
  logic [NUM_IN-1:0] hit_bits;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
    assign chk_bits[i] = chk_mask[i] & ~src_oh[i];
    assign hit_bits[i] = chk_bits[i] & (samp_data[i] == chk_val[i]);
  end

  always_comb begin
    if (comb_mode == COMB_ALL) match = (hit_bits == chk_bits);
    else                       match = (chk_bits == '0) || (|hit_bits);
  end
endmodule

// File: rtl/trig_edge_qualifier.sv
module trig_edge_qualifier
  import trig_qual_pkg::*;
#(
  parameter int unsigned NUM_IN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [NUM_IN-1:0] cfg_wdata,
  input  logic              samp_valid,
  input  logic [NUM_IN-1:0] samp_data,
  output logic              trig_out,
  output logic              qual_out
);
  localparam int unsigned SRC_W = $clog2(NUM_IN);

  logic [NUM_IN-1:0] chk_mask, chk_val, src_oh;
  logic [SRC_W-1:0]  src_idx;
  edge_pol_e         edge_pol;
  combine_e          comb_mode;
  logic              edge_hit, qual_now;

  trig_cfg_regs #(.NUM_IN(NUM_IN), .SRC_W(SRC_W), .CFG_W(NUM_IN)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .chk_mask(chk_mask), .chk_val(chk_val),
    .src_idx(src_idx), .edge_pol(edge_pol), .comb_mode(comb_mode)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_src
    assign src_oh[i] = (src_idx == SRC_W'(i));
  end

  trig_edge_detect #(.NUM_IN(NUM_IN)) u_edge (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
    .src_oh(src_oh), .edge_pol(edge_pol), .edge_hit(edge_hit)
  );

  trig_qualifier #(.NUM_IN(NUM_IN)) u_qual (
    .samp_data(samp_data), .chk_mask(chk_mask), .chk_val(chk_val),
    .src_oh(src_oh), .comb_mode(comb_mode), .match(qual_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_out <= 1'b0;
      qual_out <= 1'b0;
    end else begin
      trig_out <= samp_valid & edge_hit & qual_now;
      if (samp_valid) qual_out <= qual_now;
    end
  end

  // R9: the trigger never lasts two cycles
  assert_trig_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);

  // R9: a trigger always comes with a true qualifier for the same beat
  assert_trig_qual_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> qual_out);

  // R10: no trigger without an accepted beat
  assert_trig_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> $past(samp_valid));

  // R10: qualifier output held across idle cycles
  assert_qual_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_valid |=> $stable(qual_out));
endmodule

// File: tb/tb_trig_edge_qualifier.sv
module tb_trig_edge_qualifier;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       samp_valid = 1'b0;
  logic [7:0] samp_data = '0;
  logic       trig_out, qual_out;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  logic [7:0] m_mask = '0, m_val = '0, m_prev = '0;
  logic [2:0] m_src = '0;
  logic       m_fall = 1'b0, m_any = 1'b0, m_have = 1'b0, m_qual = 1'b0;

  always #2 clk = ~clk;

  trig_edge_qualifier dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .samp_valid(samp_valid), .samp_data(samp_data),
    .trig_out(trig_out), .qual_out(qual_out)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic qual_model(input logic [7:0] d);
    logic [7:0] eff, hits;
    eff  = m_mask & ~(8'd1 << m_src);
    hits = ~(d ^ m_val) & eff;
    if (m_any) return (eff == 8'd0) || (hits != 8'd0);
    return hits == eff;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    samp_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      2'd0: m_mask = d;
      2'd1: m_val  = d;
      2'd2: begin m_src = d[2:0]; m_fall = d[3]; m_any = d[4]; end
      default: ;
    endcase
  endtask

  // drive one cycle, compare both outputs 1 ns after the capturing edge
  task automatic beat(input logic v, input logic [7:0] d, output logic t_exp);
    logic cur, prv, edg;
    @(negedge clk);
    samp_valid = v; samp_data = d;
    cur = d[m_src]; prv = m_prev[m_src];
    edg = m_have && (m_fall ? (prv && !cur) : (!prv && cur));
    t_exp = v && edg && qual_model(d);
    if (v) begin m_qual = qual_model(d); m_prev = d; m_have = 1'b1; end
    @(posedge clk); #1;
    if (!v)          check("R10 trig", trig_out, t_exp);
    else if (m_fall) check("R4 trig", trig_out, t_exp);
    else             check("R3 trig", trig_out, t_exp);
    if (m_any) check("R7 qual", qual_out, m_qual);
    else       check("R6 qual", qual_out, m_qual);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic t;
    logic [7:0] masks [4];
    logic [7:0] vals  [4];
    masks = '{8'h00, 8'hFF, 8'h3C, 8'h81};
    vals  = '{8'h00, 8'hA5, 8'h14, 8'h81};

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 trig reset", trig_out, 1'b0);
    check("R1 qual reset", qual_out, 1'b0);

    // R5: first beat after reset is a rising step yet must not fire
    beat(1'b1, 8'h01, t); check("R5 first beat", trig_out, 1'b0);
    check("R1 default empty mask qual", qual_out, 1'b1);
    beat(1'b1, 8'h00, t);
    beat(1'b1, 8'h01, t); check("R3 rising default", trig_out, 1'b1);
    beat(1'b0, 8'h00, t); check("R9 pulse drop", trig_out, 1'b0);
    check("R9 qual held", qual_out, 1'b1);

    // R2: spare address write has no effect
    wr(2'd3, 8'hFF);
    beat(1'b1, 8'h00, t);
    beat(1'b1, 8'h01, t); check("R2 spare addr", trig_out, 1'b1);

    // R8: source bit checked against 0 in mask is still ignored
    wr(2'd0, 8'hFF); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    beat(1'b1, 8'h00, t);
    beat(1'b1, 8'h01, t); check("R8 source excluded", trig_out, 1'b1);

    // R7: any-of with only the source bit masked counts as true
    wr(2'd0, 8'h01); wr(2'd2, 8'h10);
    beat(1'b1, 8'h02, t); check("R7 empty any", qual_out, 1'b1);

    // R10: idle beats keep the previous accepted sample
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);
    beat(1'b1, 8'h00, t);
    beat(1'b0, 8'h01, t); check("R10 idle no trig", trig_out, 1'b0);
    beat(1'b1, 8'h01, t); check("R10 history kept", trig_out, 1'b1);
    beat(1'b0, 8'h00, t);
    beat(1'b1, 8'h01, t); check("R10 idle not stored", trig_out, 1'b0);

    // sweep every source, edge, mode and several patterns over all data values
    for (int s = 0; s < 8; s++) begin
      for (int e = 0; e < 2; e++) begin
        for (int md = 0; md < 2; md++) begin
          for (int p = 0; p < 4; p++) begin
            wr(2'd0, masks[p]);
            wr(2'd1, vals[p]);
            wr(2'd2, {3'b000, md[0], e[0], s[2:0]});
            for (int i = 0; i < 256; i++) begin
              beat((i % 5) != 4, 8'((i * 73 + s * 11 + p) & 255), t);
            end
          end
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule